// File: doc/BRIEF.md
# Event monitor capture controller

This block decides which built events are copied into a monitor ring buffer of 128 event slots, and when copying stops. An upstream event builder presents one strobe per built event. The strobe carries the event number and two error flags: a CRC error, and a mismatch of the event, orbit or bunch number. The controller answers with a registered save strobe and the slot to write. A buffer memory beside it uses that slot as its write address. The buffer memory and the payload readout are outside this block.

Events are chosen in one of two ways. A 16-bit prescale keeps one event in every (value+1). A mask mode keeps only event numbers whose low bits are all zero, and the number of those bits is set by a 4-bit code. With no catch enable set, capture halts once the buffer is full. With a catch enable set, the ring keeps overwriting old events until an enabled error arrives. It then keeps a fixed number of further events and freezes. A write to the control inputs applies a new configuration and re-arms the block.

Top module: `evmon_capture`

## Requirements
- R1: After reset, save_o, save_addr_o, wr_ptr_o, post_cnt_o, err_type_o, full_o, triggered_o and frozen_o are all zero. The configuration is all zero: prescale 0, no mask mode, no catch enable.
- R2: In prescale mode (cfg_mask_mode=0), the first accepted event after arming is saved, and after it every (cfg_prescale+1)-th event. The prescale phase advances on every event the block is not frozen for, whether or not buf_avail is high.
- R3: In mask mode (cfg_mask_mode=1), with code k=cfg_mask_code, an event is saved only when bits (19-k) down to 0 of ev_num are all zero. So k=15 needs the low 5 bits clear and k=0 needs the low 20 bits clear.
- R4: An event presented at one clock edge gives save_o=1 for the following cycle, with save_addr_o set to the slot written. wr_ptr_o then holds the next slot, and it counts modulo 128.
- R5: With both catch enables clear, full_o and frozen_o rise together with the 128th save, and no later event is saved until re-armed.
- R6: With a catch enable set, saving continues past 128 events. The pointer wraps, full_o stays 1 and frozen_o stays 0.
- R7: In catch mode, the first event carrying an enabled error is saved even if the selection rule rejects it, and triggered_o rises with that save. An error type whose enable is clear neither triggers nor forces a save.
- R8: After the trigger, post_cnt_o counts the saved events, not counting the trigger event. frozen_o rises with the 64th of them, and no event is saved afterwards.
- R9: err_type_o bit 0 means CRC error and bit 1 means number mismatch; bits 7..2 read 0. It is the OR of the enabled error flags of the saved events, and it never loses a bit until re-armed.
- R10: While buf_avail is low, no event is saved and no trigger happens. The pointer and post_cnt_o stay unchanged, so post_cnt_o stays below 64 if building stalls.
- R11: A cfg_wr pulse latches the configuration and clears the pointer, post_cnt_o, err_type_o, full_o, triggered_o, frozen_o and the prescale phase. An event presented in the same cycle as cfg_wr is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write and re-arm pulse |
| cfg_catch_crc | input | 1 | Catch on CRC error |
| cfg_catch_mis | input | 1 | Catch on event/orbit/bunch number mismatch |
| cfg_mask_mode | input | 1 | 1: event-number mask selection, 0: prescale |
| cfg_mask_code | input | 4 | Mask code k; low (20-k) bits must be zero |
| cfg_prescale | input | 16 | Keep one event in (value+1) |
| ev_valid | input | 1 | One-cycle strobe per built event |
| ev_num | input | 24 | Event number |
| ev_crc_err | input | 1 | Event has a CRC error |
| ev_mis_err | input | 1 | Event has a number mismatch |
| buf_avail | input | 1 | Monitor buffer can accept a write |
| save_o | output | 1 | Copy this event to the buffer |
| save_addr_o | output | 7 | Slot being written |
| wr_ptr_o | output | 7 | Next slot to write |
| post_cnt_o | output | 8 | Events saved after the trigger |
| err_type_o | output | 8 | Accumulated enabled error types |
| full_o | output | 1 | At least 128 events stored |
| triggered_o | output | 1 | Enabled error captured |
| frozen_o | output | 1 | Capture stopped |

## Verification
A wrong prescale phase or a wrong mask width shows on save_o one cycle after the offending event, as a save at the wrong position in a known sequence. A stored-count or post-trigger counter that is off by one shows on frozen_o and post_cnt_o at the exact event where the freeze is due: one event early or late, with wr_ptr_o landing on the wrong slot. A re-arm that fails to clear state shows on the first cycle after cfg_wr as a non-zero pointer, count or error byte.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int EVN_W    = 24;
  localparam int MASK_TOP = 20;
  localparam int PRESC_W  = 16;
  localparam int ERR_BITS = 2;

  typedef struct packed {
    logic [ERR_BITS-1:0] catch_en;   // [0] crc, [1] mismatch
    logic                mask_mode;
    logic [3:0]          mask_code;
    logic [PRESC_W-1:0]  prescale;
  } mon_cfg_t;
endpackage

// File: rtl/evmon_select.sv
module evmon_select #(
  parameter int EVN_W    = 24,
  parameter int MASK_TOP = 20,
  parameter int PRESC_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               adv,
  input  logic               mask_mode,
  input  logic [3:0]         mask_code,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [EVN_W-1:0]   ev_num,
  output logic               sel
);
  logic [PRESC_W-1:0] phase;
  logic [EVN_W-1:0]   low_mask;

  always_ff @(posedge clk) begin
    if (rst || clr)
      phase <= '0;
    else if (adv)
      phase <= (phase == prescale) ? '0 : phase + 1'b1;
  end

  always_comb begin
    int lim;
    lim = MASK_TOP - int'(mask_code);
    for (int i = 0; i < EVN_W; i++)
      low_mask[i] = (i < lim);
  end

  assign sel = mask_mode ? ((ev_num & low_mask) == '0) : (phase == '0);
endmodule

// File: rtl/evmon_ring.sv
module evmon_ring #(
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  output logic          save_o,
  output logic [AW-1:0] save_addr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          full_o,
  output logic          last_slot
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] LAST_CNT = (AW+1)'(DEPTH - 1);

  logic [AW:0] stored;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      save_o      <= 1'b0;
      save_addr_o <= '0;
      wr_ptr_o    <= '0;
      stored      <= '0;
    end else begin
      save_o <= push;
      if (push) begin
        save_addr_o <= wr_ptr_o;
        wr_ptr_o    <= wr_ptr_o + 1'b1;
        if (stored != FULL_CNT)
          stored <= stored + 1'b1;
      end
    end
  end

  assign full_o    = (stored == FULL_CNT);
  assign last_slot = (stored == LAST_CNT);
endmodule

// File: rtl/evmon_catch.sv
module evmon_catch #(
  parameter int POST  = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ev_in,
  input  logic             avail,
  input  logic             sel,
  input  logic             err_hit,
  input  logic             catch_any,
  input  logic             last_slot,
  output logic             adv,
  output logic             do_save,
  output logic             triggered_o,
  output logic             frozen_o,
  output logic [CNT_W-1:0] post_cnt_o
);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST - 1);

  logic trig_now;

  assign adv      = ev_in & ~frozen_o;
  assign trig_now = adv & avail & catch_any & ~triggered_o & err_hit;
  assign do_save  = adv & avail & (sel | trig_now);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      triggered_o <= 1'b0;
      frozen_o    <= 1'b0;
      post_cnt_o  <= '0;
    end else begin
      if (trig_now)
        triggered_o <= 1'b1;
      if (do_save && triggered_o) begin
        post_cnt_o <= post_cnt_o + 1'b1;
        if (post_cnt_o == POST_LAST)
          frozen_o <= 1'b1;
      end
      if (do_save && !catch_any && last_slot)
        frozen_o <= 1'b1;
    end
  end
endmodule

// File: rtl/evmon_capture.sv
module evmon_capture
  import evmon_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int POST  = 64,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic               cfg_catch_crc,
  input  logic               cfg_catch_mis,
  input  logic               cfg_mask_mode,
  input  logic [3:0]         cfg_mask_code,
  input  logic [PRESC_W-1:0] cfg_prescale,
  input  logic               ev_valid,
  input  logic [EVN_W-1:0]   ev_num,
  input  logic               ev_crc_err,
  input  logic               ev_mis_err,
  input  logic               buf_avail,
  output logic               save_o,
  output logic [AW-1:0]      save_addr_o,
  output logic [AW-1:0]      wr_ptr_o,
  output logic [CNT_W-1:0]   post_cnt_o,
  output logic [7:0]         err_type_o,
  output logic               full_o,
  output logic               triggered_o,
  output logic               frozen_o
);
  mon_cfg_t            cfg;
  logic [ERR_BITS-1:0] err_acc;
  logic [ERR_BITS-1:0] err_now;
  logic sel, adv, do_save, last_slot, ev_in;

  always_ff @(posedge clk) begin
    if (rst)
      cfg <= '0;
    else if (cfg_wr)
      cfg <= '{catch_en:  {cfg_catch_mis, cfg_catch_crc},
               mask_mode: cfg_mask_mode,
               mask_code: cfg_mask_code,
               prescale:  cfg_prescale};
  end

  assign ev_in   = ev_valid & ~cfg_wr;
  assign err_now = {ev_mis_err, ev_crc_err} & cfg.catch_en;

  evmon_select #(.EVN_W(EVN_W), .MASK_TOP(MASK_TOP), .PRESC_W(PRESC_W)) u_sel (
    .clk(clk), .rst(rst), .clr(cfg_wr), .adv(adv),
    .mask_mode(cfg.mask_mode), .mask_code(cfg.mask_code),
    .prescale(cfg.prescale), .ev_num(ev_num), .sel(sel)
  );

  evmon_catch #(.POST(POST), .CNT_W(CNT_W)) u_catch (
    .clk(clk), .rst(rst), .clr(cfg_wr), .ev_in(ev_in), .avail(buf_avail),
    .sel(sel), .err_hit(|err_now), .catch_any(|cfg.catch_en),
    .last_slot(last_slot), .adv(adv), .do_save(do_save),
    .triggered_o(triggered_o), .frozen_o(frozen_o), .post_cnt_o(post_cnt_o)
  );

  evmon_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .clr(cfg_wr), .push(do_save),
    .save_o(save_o), .save_addr_o(save_addr_o), .wr_ptr_o(wr_ptr_o),
    .full_o(full_o), .last_slot(last_slot)
  );

  always_ff @(posedge clk) begin
    if (rst || cfg_wr)
      err_acc <= '0;
    else if (do_save)
      err_acc <= err_acc | err_now;
  end

  assign err_type_o = {{(8-ERR_BITS){1'b0}}, err_acc};
endmodule

// File: rtl/evmon_capture_chk.sv
module evmon_capture_chk #(
  parameter int AW    = 7,
  parameter int POST  = 64,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_wr,
  input logic             buf_avail,
  input logic             save_o,
  input logic [AW-1:0]    save_addr_o,
  input logic [AW-1:0]    wr_ptr_o,
  input logic [CNT_W-1:0] post_cnt_o,
  input logic [7:0]       err_type_o,
  input logic             full_o,
  input logic             triggered_o,
  input logic             frozen_o
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    save_o |-> wr_ptr_o == AW'(save_addr_o + 1'b1)); // R4
  AST_NO_SAVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && !cfg_wr) |=> !save_o); // R5
  AST_FROZEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && !triggered_o) |-> full_o); // R5
  AST_TRIG_SAVE: assert property (@(posedge clk) disable iff (rst)
    $rose(triggered_o) |-> save_o); // R7
  AST_POST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    post_cnt_o <= CNT_W'(POST)); // R8
  AST_FROZEN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (frozen_o && triggered_o) |-> post_cnt_o == CNT_W'(POST)); // R8
  AST_ERR_GROW: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> (err_type_o & $past(err_type_o)) == $past(err_type_o)); // R9
  AST_NO_AVAIL: assert property (@(posedge clk) disable iff (rst)
    !buf_avail |=> !save_o); // R10
  AST_REARM: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (wr_ptr_o == '0 && !frozen_o && !triggered_o &&
                post_cnt_o == '0 && err_type_o == '0)); // R11
endmodule

bind evmon_capture evmon_capture_chk #(.AW(AW), .POST(POST), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .buf_avail(buf_avail),
  .save_o(save_o), .save_addr_o(save_addr_o), .wr_ptr_o(wr_ptr_o),
  .post_cnt_o(post_cnt_o), .err_type_o(err_type_o), .full_o(full_o),
  .triggered_o(triggered_o), .frozen_o(frozen_o)
);

// File: tb/evmon_capture_bench.sv
module evmon_capture_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, cfg_catch_crc = 0, cfg_catch_mis = 0, cfg_mask_mode = 0;
  logic [3:0] cfg_mask_code = 0;
  logic [15:0] cfg_prescale = 0;
  logic ev_valid = 0, ev_crc_err = 0, ev_mis_err = 0, buf_avail = 1;
  logic [23:0] ev_num = 0;
  logic save_o, full_o, triggered_o, frozen_o;
  logic [6:0] save_addr_o, wr_ptr_o;
  logic [7:0] post_cnt_o, err_type_o;

  int n_chk = 0, n_fail = 0, exp_ptr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evmon_capture u_evmon_capture (.*);

  // {event number, buf_avail, expected save}; mask code 15: low 5 bits zero
  localparam logic [25:0] VEC [8] = '{
    {24'h000020, 1'b1, 1'b1}, {24'h000021, 1'b1, 1'b0},
    {24'h000040, 1'b1, 1'b1}, {24'h00003F, 1'b1, 1'b0},
    {24'h000060, 1'b0, 1'b0}, {24'h000080, 1'b1, 1'b1},
    {24'h0000A1, 1'b1, 1'b0}, {24'h001000, 1'b1, 1'b1}};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm(bit crc, bit mis, bit mm, int code, int presc);
    cfg_catch_crc = crc; cfg_catch_mis = mis; cfg_mask_mode = mm;
    cfg_mask_code = 4'(code); cfg_prescale = 16'(presc);
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    exp_ptr = 0;
  endtask

  task automatic send(int evn, bit crc, bit mis, bit avail);
    ev_num = 24'(evn); ev_crc_err = crc; ev_mis_err = mis; buf_avail = avail;
    ev_valid = 1;
    @(negedge clk);
    ev_valid = 0; ev_crc_err = 0; ev_mis_err = 0; buf_avail = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 save", save_o, 0);  check("R1 ptr", wr_ptr_o, 0);
    check("R1 post", post_cnt_o, 0); check("R1 err", err_type_o, 0);
    check("R1 flags", {full_o, triggered_o, frozen_o}, 0);

    // R3 / R4 / R10 table walk, mask code 15
    arm(0, 0, 1, 15, 0);
    foreach (VEC[i]) begin
      send(int'(VEC[i][25:2]), 0, 0, VEC[i][1]);
      check("R3 save", save_o, VEC[i][0]);
      if (VEC[i][0]) begin
        check("R4 addr", save_addr_o, exp_ptr);
        exp_ptr++;
      end
      check("R4 ptr", wr_ptr_o, exp_ptr);
    end
    // R3 code 0: low 20 bits
    arm(0, 0, 1, 0, 0);
    send(24'h100000, 0, 0, 1); check("R3 k0 hit", save_o, 1);
    send(24'h080000, 0, 0, 1); check("R3 k0 miss", save_o, 0);

    // R2 prescale 2: saves at events 0 and 3
    arm(0, 0, 0, 0, 2);
    for (int i = 0; i < 6; i++) begin
      send(i, 0, 0, 1);
      check("R2 prescale", save_o, (i % 3) == 0);
    end

    // R5 stop at full
    arm(0, 0, 0, 0, 0);
    for (int i = 0; i < 127; i++) send(i, 0, 0, 1);
    check("R5 not full", full_o, 0);
    send(127, 0, 0, 1);
    check("R5 full", full_o, 1); check("R5 frozen", frozen_o, 1);
    check("R4 wrap", wr_ptr_o, 0);
    send(128, 0, 0, 1);
    check("R5 no save", save_o, 0);

    // R6 / R7 / R8 / R9 catch on crc
    arm(1, 0, 0, 0, 0);
    check("R11 rearm ptr", wr_ptr_o, 0); check("R11 rearm frozen", frozen_o, 0);
    for (int i = 0; i < 200; i++) send(i, 0, 0, 1);
    check("R6 full", full_o, 1); check("R6 not frozen", frozen_o, 0);
    check("R6 ptr", wr_ptr_o, 72);
    send(200, 1, 0, 1);
    check("R7 trig save", save_o, 1); check("R7 trig addr", save_addr_o, 72);
    check("R7 triggered", triggered_o, 1); check("R9 crc bit", err_type_o, 1);
    for (int i = 0; i < 63; i++) send(201 + i, 0, i == 5, 1);
    check("R8 post63", post_cnt_o, 63); check("R8 not yet", frozen_o, 0);
    send(264, 0, 0, 1);
    check("R8 post64", post_cnt_o, 64); check("R8 frozen", frozen_o, 1);
    check("R8 ptr", wr_ptr_o, 9);
    check("R9 disabled type", err_type_o, 1);
    send(265, 1, 0, 1);
    check("R8 no save", save_o, 0);

    // R7 / R9 / R10 catch on mismatch, prescale 3
    arm(0, 1, 0, 0, 3);
    send(0, 0, 0, 1); check("R2 first", save_o, 1);
    send(1, 1, 0, 1);
    check("R7 crc ignored", save_o, 0); check("R7 no trig", triggered_o, 0);
    send(2, 0, 1, 1);
    check("R7 forced save", save_o, 1); check("R9 mis bit", err_type_o, 2);
    send(3, 0, 0, 0);
    check("R10 suppressed", save_o, 0); check("R10 post", post_cnt_o, 0);
    send(4, 0, 0, 1);
    check("R10 post one", post_cnt_o, 1); check("R10 early stop", frozen_o, 0);

    // R11 event in same cycle as cfg_wr is ignored
    cfg_catch_mis = 0; cfg_prescale = 0; ev_valid = 1; ev_num = 0; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; ev_valid = 0;
    check("R11 ignored", save_o, 0); check("R11 ptr", wr_ptr_o, 0);
    check("R11 err", err_type_o, 0); check("R11 trig", triggered_o, 0);
    check("R11 post", post_cnt_o, 0);
    send(7, 0, 0, 1);
    check("R11 new cfg", save_o, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule